// File: doc/BRIEF.md
# Programmable Parallel Port Core

This block gives a processor three 8-bit parallel ports, called A, B and C, through a small register window. A 2-bit address picks one of four registers. Address 0 is port A, address 1 is port B, address 2 is port C and address 3 is the configuration register. Writes and reads use the same map.

Writing to the configuration register does one of two things, and bit 7 of the written byte decides which. With bit 7 set, the byte becomes the configuration word: it sets the direction of each port and the operating mode of each port group. With bit 7 clear, the byte sets or clears one bit of port C.

The core holds an output latch for each port. For every pin it drives an output value and an output enable, and it reads back the live pin level. In the strobed modes, some port C pins belong to a separate handshake and interrupt block. That block is not part of this core. The core marks those pins on `pc_hs_own`, never drives them, and exposes the configuration word on `cfg_word` so the handshake block can follow the modes.

The bus uses plain single-cycle strobes, not valid/ready. Every access completes in the cycle it is presented, so there is no back-pressure. Read data is combinational from the address. A write takes effect on the clock edge where `bus_wr` is high.

Top module: `ppi_core`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration register, for both `bus_wr` and `bus_rd`.
- R2: After reset, `cfg_word` reads back as 0x9B, all output enables are 0, all output latches are 0 and `pc_hs_own` is 0.
- R3: In a configuration word, bits 6:5 give the group A mode (00 = mode 0, 01 = mode 1, 1x = mode 2) and bit 2 gives the group B mode (1 = mode 1). The direction bits are bit 4 for port A, bit 3 for port C bits 7:4, bit 1 for port B and bit 0 for port C bits 3:0, where 1 means input.
- R4: A configuration-address write with bit 7 = 0 writes the value of bit 0 into the port C latch bit selected by bits 3:1. Bits 6:4 have no effect, and the stored configuration word does not change.
- R5: When a configuration word is written, every latch bit that is not writable under the new word is cleared to 0. Writable bits keep their value.
- R6: Some port C bits are reserved for handshake in the strobed modes:
  - Group B mode 1 reserves bits 2:0.
  - Group A mode 2 reserves bits 7:3.
  - Group A mode 1 with port A as input reserves bits 5:3.
  - Group A mode 1 with port A as output reserves bits 7, 6 and 3.
  
  Reserved bits are flagged on `pc_hs_own`, their output enable is 0, and they are not writable.
- R7: A set/reset command that targets a reserved or input bit leaves that port C latch bit unchanged.
- R8: A read of address 3 returns the last configuration word written.
- R9: A port read returns the latch for writable bits and the live pin level for the other bits.
- R10: A data write changes only the writable latch bits. All other bits keep their value.
- R11: Each output enable equals the writable-mask bit for that pin. The enables change only on the clock edge that takes a configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| cfg_word | output | 8 | Current configuration word |
| pa_out | output | 8 | Port A latch value |
| pa_oe | output | 8 | Port A per-pin output enable |
| pa_in | input | 8 | Port A pin levels |
| pb_out | output | 8 | Port B latch value |
| pb_oe | output | 8 | Port B per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pc_out | output | 8 | Port C latch value |
| pc_oe | output | 8 | Port C per-pin output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_hs_own | output | 8 | Port C pins reserved for the handshake block |

## Verification
The bench covers several corner cases, each of which would expose a specific wrong design:
- Mixed port C nibble directions. A design that used one direction for the whole port would corrupt the input half on writes, or return latch data where live pins are expected.
- Each strobed mode, including the two group A mode 1 variants. A design with the wrong reservation mask would drive pins the handshake block owns.
- Set/reset commands with bits 6:4 set. A design that decodes those bits would change the wrong latch bit or overwrite the configuration word.
- Set/reset commands aimed at reserved bits. A design that writes these would leak data onto handshake pins.
- Latch clearing after a port is switched to input and then back to output. A design that skips the clear would bring stale data back onto the pins.
- The enable timing around a configuration write. A design that registered the enables one cycle late would be caught on the first clock edge after the write.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int NPORTS   = 3;
  localparam logic [PORT_W-1:0] RESET_CFG = 8'h9B;

  localparam logic [ADDR_W-1:0] ADR_PA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_PB  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_PC  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CFG = 2'd3;

  // handshake reservations on port C, by mode
  localparam logic [PORT_W-1:0] HS_B_M1     = 8'h07;
  localparam logic [PORT_W-1:0] HS_A_M2     = 8'hF8;
  localparam logic [PORT_W-1:0] HS_A_M1_IN  = 8'h38;
  localparam logic [PORT_W-1:0] HS_A_M1_OUT = 8'hC8;

  typedef struct packed {
    logic [PORT_W-1:0] a;
    logic [PORT_W-1:0] b;
    logic [PORT_W-1:0] c;
    logic [PORT_W-1:0] hs;
  } wmask_t;

  function automatic wmask_t masks_of(input logic [PORT_W-1:0] w);
    wmask_t r;
    r.a  = w[4] ? '0 : '1;
    r.b  = w[1] ? '0 : '1;
    r.c  = {(w[3] ? 4'h0 : 4'hF), (w[0] ? 4'h0 : 4'hF)};
    r.hs = '0;
    if (w[2]) r.hs = r.hs | HS_B_M1;
    if (w[6]) r.hs = r.hs | HS_A_M2;
    else if (w[5]) r.hs = r.hs | (w[4] ? HS_A_M1_IN : HS_A_M1_OUT);
    r.c = r.c & ~r.hs;
    return r;
  endfunction
endpackage

// File: rtl/ppi_cfg_reg.sv
module ppi_cfg_reg
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PORT_W-1:0] cfg_wdata,
  output logic [PORT_W-1:0] cfg_q,
  output wmask_t            cur_mask,
  output wmask_t            new_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RESET_CFG;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_comb begin
    cur_mask = masks_of(cfg_q);
    new_mask = masks_of(cfg_wdata);
  end

  assert_cfg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wdata));
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
  assert_mode2_reserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[6] |-> (cur_mask.hs[7:3] == 5'h1F && cur_mask.c[7:3] == 5'h00));
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  input  logic         clr_en,
  input  logic [W-1:0] keep_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr_en) q <= q & keep_mask;
    else if (wr_en)  q <= (q & ~wr_mask) | (wr_data & wr_mask);
  end

  assert_write_scope_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((q ^ $past(q)) & ~($past(wr_en) ? $past(wr_mask) : '0)) == '0);
  assert_clear_inputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (q & ~$past(keep_mask)) == '0);
endmodule

// File: rtl/ppi_rd_mux.sv
module ppi_rd_mux
  import ppi_pkg::*;
(
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NPORTS-1:0][PORT_W-1:0] latch,
  input  logic [NPORTS-1:0][PORT_W-1:0] wmask,
  input  logic [NPORTS-1:0][PORT_W-1:0] pins,
  input  logic [PORT_W-1:0]             cfg,
  output logic [PORT_W-1:0]             rdata
);
  logic [NPORTS-1:0][PORT_W-1:0] view;

  for (genvar i = 0; i < NPORTS; i++) begin : g_view
    assign view[i] = (latch[i] & wmask[i]) | (pins[i] & ~wmask[i]);
  end

  always_comb begin
    unique case (addr)
      ADR_PA:  rdata = view[0];
      ADR_PB:  rdata = view[1];
      ADR_PC:  rdata = view[2];
      default: rdata = cfg;
    endcase
  end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] cfg_word,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_hs_own
);
  localparam int SEL_W = $clog2(PORT_W);

  logic   cfg_we, bsr_we;
  wmask_t cur_m, new_m;
  logic [SEL_W-1:0] bsr_sel;

  logic [NPORTS-1:0]             l_wr;
  logic [NPORTS-1:0][PORT_W-1:0] l_mask, l_data, l_keep, l_q, cur_w, pins;

  assign cfg_we  = bus_wr && bus_addr == ADR_CFG &&  bus_wdata[7];
  assign bsr_we  = bus_wr && bus_addr == ADR_CFG && !bus_wdata[7];
  assign bsr_sel = bus_wdata[SEL_W:1];

  ppi_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(bus_wdata),
    .cfg_q    (cfg_word),
    .cur_mask (cur_m),
    .new_mask (new_m)
  );

  assign cur_w  = {cur_m.c, cur_m.b, cur_m.a};
  assign l_keep = {new_m.c, new_m.b, new_m.a};
  assign pins   = {pc_in, pb_in, pa_in};

  // ports A and B: plain byte writes
  for (genvar i = 0; i < NPORTS - 1; i++) begin : g_ab
    assign l_wr[i]   = bus_wr && bus_addr == ADDR_W'(i);
    assign l_mask[i] = cur_w[i];
    assign l_data[i] = bus_wdata;
  end

  // port C: byte write or single-bit set/reset
  assign l_wr[2]   = (bus_wr && bus_addr == ADR_PC) || bsr_we;
  assign l_mask[2] = bsr_we ? (cur_w[2] & (PORT_W'(1) << bsr_sel)) : cur_w[2];
  assign l_data[2] = bsr_we ? {PORT_W{bus_wdata[0]}} : bus_wdata;

  for (genvar i = 0; i < NPORTS; i++) begin : g_latch
    ppi_latch #(.W(PORT_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (l_wr[i]),
      .wr_mask  (l_mask[i]),
      .wr_data  (l_data[i]),
      .clr_en   (cfg_we),
      .keep_mask(l_keep[i]),
      .q        (l_q[i])
    );
  end

  ppi_rd_mux u_rd (
    .addr (bus_addr),
    .latch(l_q),
    .wmask(cur_w),
    .pins (pins),
    .cfg  (cfg_word),
    .rdata(bus_rdata)
  );

  assign pa_out    = l_q[0];
  assign pb_out    = l_q[1];
  assign pc_out    = l_q[2];
  assign pa_oe     = cur_w[0];
  assign pb_oe     = cur_w[1];
  assign pc_oe     = cur_w[2];
  assign pc_hs_own = cur_m.hs;

  assert_oe_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
  assert_cfg_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADR_CFG) |-> bus_rdata == cfg_word);
  assert_hs_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_oe & pc_hs_own) == '0);
  assert_bsr_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_we |=> ((pc_out ^ $past(pc_out)) & $past(pc_hs_own)) == '0);
endmodule

// File: tb/ppi_core_test.sv
module ppi_core_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata, cfg_word;
  logic [7:0] pa_out, pa_oe, pa_in = '0;
  logic [7:0] pb_out, pb_oe, pb_in = '0;
  logic [7:0] pc_out, pc_oe, pc_in = '0;
  logic [7:0] pc_hs_own;

  int n_chk = 0, n_err = 0;

  ppi_core uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R2 pa_oe", pa_oe, 8'h00);
    chk("R2 pb_oe", pb_oe, 8'h00);
    chk("R2 pc_oe", pc_oe, 8'h00);
    chk("R2 pc_out", pc_out, 8'h00);
    chk("R2 hs", pc_hs_own, 8'h00);
    rd(2'd3, v); chk("R2 cfg readback", v, 8'h9B);
    pa_in = 8'h5A; pb_in = 8'hC3;
    rd(2'd0, v); chk("R1 R9 read A pins", v, 8'h5A);
    rd(2'd1, v); chk("R1 R9 read B pins", v, 8'hC3);
    wr(2'd0, 8'hFF); chk("R10 input A write ignored", pa_out, 8'h00);
  endtask

  task automatic t_all_out;
    logic [7:0] v;
    wr(2'd3, 8'h80);
    chk("R3 R11 pa_oe", pa_oe, 8'hFF);
    chk("R3 R11 pb_oe", pb_oe, 8'hFF);
    chk("R3 R11 pc_oe", pc_oe, 8'hFF);
    wr(2'd0, 8'h3C); chk("R1 pa_out", pa_out, 8'h3C);
    rd(2'd0, v);     chk("R9 read A latch", v, 8'h3C);
    wr(2'd1, 8'h81); chk("R1 pb_out", pb_out, 8'h81);
    wr(2'd2, 8'hA5); chk("R1 pc_out", pc_out, 8'hA5);
  endtask

  task automatic t_split_c;
    logic [7:0] v;
    wr(2'd3, 8'h88);
    chk("R3 split pc_oe", pc_oe, 8'h0F);
    chk("R5 upper cleared", pc_out, 8'h05);
    chk("R5 A kept", pa_out, 8'h3C);
    wr(2'd2, 8'hFF); chk("R10 lower only", pc_out, 8'h0F);
    pc_in = 8'h90;
    rd(2'd2, v); chk("R9 mixed C read", v, 8'h9F);
  endtask

  task automatic t_bsr;
    logic [7:0] v;
    wr(2'd3, 8'h80); chk("R5 nothing cleared", pc_out, 8'h0F);
    wr(2'd3, 8'h7F); chk("R4 set bit7 ignore 6:4", pc_out, 8'h8F);
    wr(2'd3, 8'h06); chk("R4 clear bit3", pc_out, 8'h87);
    wr(2'd3, 8'h09); chk("R4 set bit4", pc_out, 8'h97);
    rd(2'd3, v);     chk("R4 R8 cfg unchanged", v, 8'h80);
  endtask

  task automatic t_clear;
    wr(2'd3, 8'h92);
    chk("R5 A cleared", pa_out, 8'h00);
    chk("R5 B cleared", pb_out, 8'h00);
    chk("R5 C kept", pc_out, 8'h97);
    wr(2'd3, 8'h80);
    chk("R5 A stays clear", pa_out, 8'h00);
    chk("R5 B stays clear", pb_out, 8'h00);
  endtask

  task automatic t_oe_timing;
    @(negedge clk);
    bus_addr = 2'd3; bus_wdata = 8'h9B; bus_wr = 1'b1;
    #1 chk("R11 oe before edge", pa_oe, 8'hFF);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R11 oe after edge", pa_oe, 8'h00);
    chk("R11 pc_oe after edge", pc_oe, 8'h00);
  endtask

  task automatic t_hs_modes;
    logic [7:0] v;
    wr(2'd3, 8'hC4);
    chk("R6 A2+B1 hs", pc_hs_own, 8'hFF);
    chk("R6 A2+B1 oe", pc_oe, 8'h00);
    chk("R3 A2 pa_oe", pa_oe, 8'hFF);
    wr(2'd3, 8'hA0);
    chk("R6 A1 out hs", pc_hs_own, 8'hC8);
    chk("R6 A1 out oe", pc_oe, 8'h37);
    wr(2'd3, 8'hB0);
    chk("R6 A1 in hs", pc_hs_own, 8'h38);
    chk("R6 A1 in oe", pc_oe, 8'hC7);
    chk("R3 A in", pa_oe, 8'h00);
    wr(2'd3, 8'h84);
    chk("R6 B1 hs", pc_hs_own, 8'h07);
    chk("R6 B1 oe", pc_oe, 8'hF8);
    rd(2'd3, v); chk("R8 cfg", v, 8'h84);
  endtask

  task automatic t_bsr_hs;
    logic [7:0] v;
    wr(2'd2, 8'hFF); chk("R6 R10 hs bits not written", pc_out, 8'hF8);
    wr(2'd3, 8'h03); chk("R7 set on hs bit", pc_out, 8'hF8);
    wr(2'd3, 8'h08); chk("R4 clear bit4", pc_out, 8'hE8);
    pc_in = 8'h05;
    rd(2'd2, v); chk("R9 C with hs pins", v, 8'hED);
  endtask

  initial begin
    fork
      begin : body
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_all_out();
        t_split_c();
        t_bsr();
        t_clear();
        t_oe_timing();
        t_hs_modes();
        t_bsr_hs();
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule